// File: doc/BRIEF.md
# Reference-counted clock gate controller

The block keeps one enable counter per entry of a fixed table of clock gates and turns each gate's control bits on and off in one of two register banks. Clients issue enable and disable requests that carry a gate index. The block touches the hardware bits only on the first enable and on the last matching disable. Repeated enables from several clients therefore share a gate without disturbing each other.

Requests are served one at a time. Each one takes two clock edges. The outcome is reported on a one-cycle done pulse, which carries an error code and, when the bits changed, a description of the set or clear that was applied. An index past the end of the table is rejected. So are a disable on an idle gate and an enable on a gate whose counter is already full. In all three cases nothing changes.

Top module: `gate_refcnt_ctl`

## Requirements
- R1: `ready_o` is high whenever no request is in flight. A request is accepted at a rising edge where `req_valid_i` and `ready_o` are both high. `ready_o` is then low for exactly one cycle, and a request presented during that cycle is ignored. After the next edge, `done_o` is high for one cycle and `ready_o` is high again.
- R2: An enable request on a valid gate raises that gate's count by one. The gate's bits are set, with `wr_valid_o`=1 and `wr_set_o`=1, only when the count was 0 before the request.
- R3: A disable request on a gate with a nonzero count lowers the count by one. The gate's bits are cleared, with `wr_valid_o`=1 and `wr_set_o`=0, only when the count was 1 before the request.
- R4: A disable request on a gate whose count is 0 reports `err_o`=1 with `err_code_o`=2. It changes no count and no register bit.
- R5: An enable request on a gate whose count is at its maximum of 2^CNT_W-1 reports `err_o`=1 with `err_code_o`=3. The count stays at the maximum and no bit changes.
- R6: A request with an index of N_GATES or more reports `err_o`=1 with `err_code_o`=1 and changes no state. A request that succeeds reports code 0 with `err_o`=0.
- R7: Gate table. Gate g sits in bank g mod 2 (0 selects `bank0_o`, 1 selects `bank1_o`) and in register (g/2) mod N_REGS. Its bit position p is 3*g mod DATA_W. Gates with g mod 4 = 3 carry the nonzero mask 0xF<<p, and that mask is used. Every other gate uses the single bit 1<<p.
- R8: A write changes only the masked bits of the selected register in the selected bank. Register r of a bank appears at bits [r*DATA_W +: DATA_W] of that bank's output. `wr_bank_o`, `wr_reg_o` and `wr_mask_o` report the bank, register and mask that were written.
- R9: After reset all counts and register bits are zero, `ready_o`=1, and `done_o`, `err_o` and `wr_valid_o` are 0.
- R10: Counts are independent. A request on one gate never changes another gate's count or bits, even when the two gates share a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_en_i | input | 1 | 1 = enable, 0 = disable |
| req_idx_i | input | $clog2(N_GATES)+1 | Gate index; may exceed the table |
| ready_o | output | 1 | Block can accept a request |
| done_o | output | 1 | One-cycle pulse: request finished |
| err_o | output | 1 | Request rejected (valid with done_o) |
| err_code_o | output | 2 | 0 ok, 1 range, 2 underflow, 3 overflow |
| wr_valid_o | output | 1 | A set or clear was applied (valid with done_o) |
| wr_bank_o | output | 1 | Bank written |
| wr_reg_o | output | $clog2(N_REGS) | Register written |
| wr_set_o | output | 1 | 1 = bits set, 0 = bits cleared |
| wr_mask_o | output | DATA_W | Mask applied |
| bank0_o | output | N_REGS*DATA_W | Bank 0 gate registers |
| bank1_o | output | N_REGS*DATA_W | Bank 1 gate registers |

## Verification
The assertions assume the table keeps the gates that share a register on disjoint bits. They also assume `req_idx_i` is stable on the edge where a request is accepted. The bench holds every request for exactly one cycle, raised and dropped just after a rising edge. Both directed and pseudo-random sequences use the default table, in which the gates sharing a register never overlap. Indices up to 9 are drawn, so out-of-range requests mix with legal ones.

// File: rtl/gate_ctl_pkg.sv
package gate_ctl_pkg;
  typedef enum logic [1:0] {
    GC_OK    = 2'd0,
    GC_RANGE = 2'd1,
    GC_UNDER = 2'd2,
    GC_OVER  = 2'd3
  } gc_err_e;
endpackage

// File: rtl/gate_table.sv
module gate_table #(
  parameter int N_GATES = 8,
  parameter int N_REGS  = 2,
  parameter int DATA_W  = 32
) (
  input  logic [$clog2(N_GATES):0]  idx_i,
  output logic                      in_range_o,
  output logic                      bank_o,
  output logic [$clog2(N_REGS)-1:0] reg_o,
  output logic [DATA_W-1:0]         mask_o
);
  localparam int GIDX_W = $clog2(N_GATES);
  localparam int RIDX_W = $clog2(N_REGS);
  localparam int IDX_W  = GIDX_W + 1;

  logic              tbl_bank [N_GATES];
  logic [RIDX_W-1:0] tbl_reg  [N_GATES];
  logic [DATA_W-1:0] tbl_mask [N_GATES];

  for (genvar g = 0; g < N_GATES; g++) begin : g_ent
    localparam int POS = (3 * g) % DATA_W;
    localparam logic [DATA_W-1:0] ONE_BIT = DATA_W'(1) << POS;
    localparam logic [DATA_W-1:0] FIELD   = (g % 4 == 3) ? (DATA_W'(4'hF) << POS) : '0;
    assign tbl_bank[g] = 1'(g % 2);
    assign tbl_reg[g]  = RIDX_W'((g / 2) % N_REGS);
    // a nonzero mask field wins over the single bit
    assign tbl_mask[g] = (FIELD != '0) ? FIELD : ONE_BIT;
  end

  logic [GIDX_W-1:0] gidx;
  assign gidx       = idx_i[GIDX_W-1:0];
  assign in_range_o = idx_i < IDX_W'(N_GATES);

  always_comb begin
    bank_o = 1'b0;
    reg_o  = '0;
    mask_o = '0;
    if (in_range_o) begin
      bank_o = tbl_bank[gidx];
      reg_o  = tbl_reg[gidx];
      mask_o = tbl_mask[gidx];
    end
  end
endmodule

// File: rtl/gate_cnt_array.sv
module gate_cnt_array #(
  parameter int N_GATES = 8,
  parameter int CNT_W   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(N_GATES)-1:0] idx_i,
  input  logic                       inc_i,
  input  logic                       dec_i,
  output logic [CNT_W-1:0]           cnt_o
);
  localparam int GIDX_W = $clog2(N_GATES);

  logic [CNT_W-1:0] cnt_q [N_GATES];

  for (genvar g = 0; g < N_GATES; g++) begin : g_cnt
    logic hit;
    assign hit = (idx_i == GIDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q[g] <= '0;
      else if (hit && inc_i) cnt_q[g] <= cnt_q[g] + 1'b1;
      else if (hit && dec_i) cnt_q[g] <= cnt_q[g] - 1'b1;
    end
  end

  assign cnt_o = cnt_q[idx_i];
endmodule

// File: rtl/gate_reg_bank.sv
module gate_reg_bank #(
  parameter int N_REGS = 2,
  parameter int DATA_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      set_i,
  input  logic [$clog2(N_REGS)-1:0] reg_i,
  input  logic [DATA_W-1:0]         mask_i,
  output logic [N_REGS*DATA_W-1:0]  regs_o
);
  localparam int RIDX_W = $clog2(N_REGS);

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && reg_i == RIDX_W'(r)) q <= set_i ? (q | mask_i) : (q & ~mask_i);
    end
    assign regs_o[r*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/gate_refcnt_ctl.sv
module gate_refcnt_ctl
  import gate_ctl_pkg::*;
#(
  parameter int N_GATES = 8,
  parameter int N_REGS  = 2,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic                      req_en_i,
  input  logic [$clog2(N_GATES):0]  req_idx_i,
  output logic                      ready_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [1:0]                err_code_o,
  output logic                      wr_valid_o,
  output logic                      wr_bank_o,
  output logic [$clog2(N_REGS)-1:0] wr_reg_o,
  output logic                      wr_set_o,
  output logic [DATA_W-1:0]         wr_mask_o,
  output logic [N_REGS*DATA_W-1:0]  bank0_o,
  output logic [N_REGS*DATA_W-1:0]  bank1_o
);
  localparam int GIDX_W = $clog2(N_GATES);
  localparam int IDX_W  = GIDX_W + 1;
  localparam int RIDX_W = $clog2(N_REGS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              busy_q, en_q;
  logic [IDX_W-1:0]  idx_q;
  logic              in_range, t_bank;
  logic [RIDX_W-1:0] t_reg;
  logic [DATA_W-1:0] t_mask;
  logic [CNT_W-1:0]  cnt_cur;
  logic              cnt_inc, cnt_dec, fire;
  gc_err_e           err_d;

  assign ready_o = !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      busy_q <= 1'b0;
    end else if (req_valid_i) begin
      busy_q <= 1'b1;
      en_q   <= req_en_i;
      idx_q  <= req_idx_i;
    end
  end

  gate_table #(.N_GATES(N_GATES), .N_REGS(N_REGS), .DATA_W(DATA_W)) u_table (
    .idx_i      (idx_q),
    .in_range_o (in_range),
    .bank_o     (t_bank),
    .reg_o      (t_reg),
    .mask_o     (t_mask)
  );

  gate_cnt_array #(.N_GATES(N_GATES), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx_q[GIDX_W-1:0]),
    .inc_i  (cnt_inc),
    .dec_i  (cnt_dec),
    .cnt_o  (cnt_cur)
  );

  always_comb begin
    err_d   = GC_OK;
    cnt_inc = 1'b0;
    cnt_dec = 1'b0;
    fire    = 1'b0;
    if (busy_q) begin
      if (!in_range) begin
        err_d = GC_RANGE;
      end else if (en_q) begin
        if (cnt_cur == CNT_MAX) err_d = GC_OVER;
        else begin
          cnt_inc = 1'b1;
          fire    = (cnt_cur == '0);
        end
      end else begin
        if (cnt_cur == '0) err_d = GC_UNDER;
        else begin
          cnt_dec = 1'b1;
          fire    = (cnt_cur == CNT_W'(1));
        end
      end
    end
  end

  logic [1:0] we_bank;
  assign we_bank = {fire && t_bank, fire && !t_bank};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [N_REGS*DATA_W-1:0] regs;
    gate_reg_bank #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we_bank[b]),
      .set_i  (en_q),
      .reg_i  (t_reg),
      .mask_i (t_mask),
      .regs_o (regs)
    );
  end
  assign bank0_o = g_bank[0].regs;
  assign bank1_o = g_bank[1].regs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      err_code_o <= GC_OK;
      wr_valid_o <= 1'b0;
      wr_bank_o  <= 1'b0;
      wr_reg_o   <= '0;
      wr_set_o   <= 1'b0;
      wr_mask_o  <= '0;
    end else begin
      done_o     <= busy_q;
      err_code_o <= err_d;
      wr_valid_o <= fire;
      wr_bank_o  <= fire ? t_bank : 1'b0;
      wr_reg_o   <= fire ? t_reg  : '0;
      wr_set_o   <= fire ? en_q   : 1'b0;
      wr_mask_o  <= fire ? t_mask : '0;
    end
  end

  assign err_o = (err_code_o != GC_OK);
endmodule

// File: rtl/gate_refcnt_ctl_chk.sv
module gate_refcnt_ctl_chk #(
  parameter int N_GATES = 8,
  parameter int N_REGS  = 2,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_valid_i,
  input logic                      req_en_i,
  input logic [$clog2(N_GATES):0]  req_idx_i,
  input logic                      ready_o,
  input logic                      done_o,
  input logic                      err_o,
  input logic [1:0]                err_code_o,
  input logic                      wr_valid_o,
  input logic                      wr_bank_o,
  input logic [$clog2(N_REGS)-1:0] wr_reg_o,
  input logic                      wr_set_o,
  input logic [DATA_W-1:0]         wr_mask_o,
  input logic [N_REGS*DATA_W-1:0]  bank0_o,
  input logic [N_REGS*DATA_W-1:0]  bank1_o
);
  localparam int IDX_W = $clog2(N_GATES) + 1;

  a_r1_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && ready_o |=> !ready_o);

  a_r1_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> done_o && ready_o);

  a_r1_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_no_wr_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !wr_valid_o);

  a_r8_wr_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> done_o);

  a_r6_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(req_valid_i && ready_o, 2) && ($past(req_idx_i, 2) >= IDX_W'(N_GATES))
    |-> err_o && err_code_o == 2'd1);

  a_r8_bank0_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank0_o) |-> wr_valid_o && !wr_bank_o);

  a_r8_bank1_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank1_o) |-> wr_valid_o && wr_bank_o);

  a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && wr_set_o |->
      (((wr_bank_o ? bank1_o[wr_reg_o*DATA_W +: DATA_W] : bank0_o[wr_reg_o*DATA_W +: DATA_W])
        & wr_mask_o) == wr_mask_o));

  a_r3_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_set_o |->
      (((wr_bank_o ? bank1_o[wr_reg_o*DATA_W +: DATA_W] : bank0_o[wr_reg_o*DATA_W +: DATA_W])
        & wr_mask_o) == '0));
endmodule

bind gate_refcnt_ctl gate_refcnt_ctl_chk #(
  .N_GATES(N_GATES), .N_REGS(N_REGS), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/gate_refcnt_ctl_tb.sv
module gate_refcnt_ctl_tb;
  localparam int CLK_P   = 10;
  localparam int N_GATES = 8;
  localparam int N_REGS  = 2;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 3;
  localparam int CMAX    = (1 << CNT_W) - 1;
  localparam int IDX_W   = $clog2(N_GATES) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_en = 1'b0;
  logic [IDX_W-1:0] req_idx = '0;
  logic ready, done, err, wr_valid, wr_bank, wr_set;
  logic [1:0] err_code;
  logic [$clog2(N_REGS)-1:0] wr_reg;
  logic [DATA_W-1:0] wr_mask;
  logic [N_REGS*DATA_W-1:0] bank0, bank1;

  always #(CLK_P/2) clk = ~clk;

  gate_refcnt_ctl #(.N_GATES(N_GATES), .N_REGS(N_REGS), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_en_i(req_en), .req_idx_i(req_idx),
    .ready_o(ready), .done_o(done), .err_o(err), .err_code_o(err_code),
    .wr_valid_o(wr_valid), .wr_bank_o(wr_bank), .wr_reg_o(wr_reg), .wr_set_o(wr_set),
    .wr_mask_o(wr_mask), .bank0_o(bank0), .bank1_o(bank1)
  );

  int checks = 0, fails = 0;
  int cnt [N_GATES];
  logic [DATA_W-1:0] mb [2][N_REGS];
  bit mon_on = 0;
  bit e_ready = 1, e_done = 0, e_wr = 0, e_set = 0, e_bank = 0;
  int e_code = 0, e_reg = 0;
  logic [DATA_W-1:0] e_mask = '0;
  string e_tag = "R2";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] gmask(int g);
    int p = (3 * g) % DATA_W;
    if (g % 4 == 3) return DATA_W'(4'hF) << p;
    return DATA_W'(1) << p;
  endfunction

  function automatic logic [N_REGS*DATA_W-1:0] flat(int b);
    logic [N_REGS*DATA_W-1:0] v;
    for (int r = 0; r < N_REGS; r++) v[r*DATA_W +: DATA_W] = mb[b][r];
    return v;
  endfunction

  // monitor: compare against the model on every falling edge
  always @(negedge clk) if (mon_on) begin
    chk("R1", "ready_o", 64'(ready), 64'(e_ready));
    chk("R1", "done_o", 64'(done), 64'(e_done));
    chk("R8", "bank0_o", 64'(bank0), 64'(flat(0)));
    chk("R8", "bank1_o", 64'(bank1), 64'(flat(1)));
    if (e_done) begin
      chk(e_tag, "err_code_o", 64'(err_code), 64'(e_code));
      chk(e_tag, "err_o", 64'(err), 64'(e_code != 0));
      chk(e_tag, "wr_valid_o", 64'(wr_valid), 64'(e_wr));
      if (e_wr) begin
        chk("R7", "wr_bank_o", 64'(wr_bank), 64'(e_bank));
        chk("R7", "wr_reg_o", 64'(wr_reg), 64'(e_reg));
        chk("R7", "wr_mask_o", 64'(wr_mask), 64'(e_mask));
        chk(e_tag, "wr_set_o", 64'(wr_set), 64'(e_set));
      end
    end else begin
      chk("R1", "wr_valid_o idle", 64'(wr_valid), 64'(0));
    end
  end

  task automatic req(bit en, int idx, bit extra_valid = 0);
    @(posedge clk); #1;
    req_valid = 1; req_en = en; req_idx = IDX_W'(idx);
    @(posedge clk); #1;
    // a request held during the busy cycle must be ignored (R1)
    req_valid = extra_valid; req_en = 1'b1; req_idx = '0;
    e_ready = 0;
    @(posedge clk); #1;
    req_valid = 0;
    e_ready = 1; e_done = 1; e_wr = 0; e_code = 0; e_set = en;
    if (idx >= N_GATES) begin
      e_code = 1; e_tag = "R6";
    end else if (en) begin
      if (cnt[idx] == CMAX) begin e_code = 3; e_tag = "R5"; end
      else begin
        e_tag = "R2";
        if (cnt[idx] == 0) e_wr = 1;
        cnt[idx]++;
      end
    end else begin
      if (cnt[idx] == 0) begin e_code = 2; e_tag = "R4"; end
      else begin
        e_tag = "R3";
        if (cnt[idx] == 1) e_wr = 1;
        cnt[idx]--;
      end
    end
    if (e_wr) begin
      e_bank = 1'(idx % 2);
      e_reg  = (idx / 2) % N_REGS;
      e_mask = gmask(idx);
      if (en) mb[e_bank][e_reg] = mb[e_bank][e_reg] | e_mask;
      else    mb[e_bank][e_reg] = mb[e_bank][e_reg] & ~e_mask;
    end
    @(posedge clk); #1;
    e_done = 0; e_wr = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int g = 0; g < N_GATES; g++) cnt[g] = 0;
    for (int b = 0; b < 2; b++) for (int r = 0; r < N_REGS; r++) mb[b][r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R9", "reset ready_o", 64'(ready), 64'(1));
    chk("R9", "reset done_o", 64'(done), 64'(0));
    chk("R9", "reset err_o", 64'(err), 64'(0));
    chk("R9", "reset wr_valid_o", 64'(wr_valid), 64'(0));
    chk("R9", "reset banks", 64'(bank0 | bank1), 64'(0));
    mon_on = 1;

    // R2/R3: first enable sets, nested ones and partial disables leave bits alone
    req(1, 0);
    chk("R2", "gate0 bit after enable", 64'(bank0[0]), 64'(1));
    req(1, 0, 1);
    req(0, 0);
    chk("R3", "gate0 bit while count 1", 64'(bank0[0]), 64'(1));
    req(0, 0);
    chk("R3", "gate0 bit after last disable", 64'(bank0[0]), 64'(0));
    // R4: underflow
    req(0, 0);
    // R6: out of range
    req(1, 8);
    req(0, 15);
    // R7/R10: mask gates sharing bank1 register 1
    req(1, 3);
    chk("R7", "gate3 mask field", 64'(bank1[DATA_W +: DATA_W]), 64'(32'h0000_1E00));
    req(1, 7);
    req(0, 3);
    chk("R10", "gate7 kept after gate3 off", 64'(bank1[DATA_W +: DATA_W]), 64'(32'h01E0_0000));
    req(0, 7);
    // R5: saturate gate 5, then unwind
    for (int i = 0; i < CMAX + 1; i++) req(1, 5);
    for (int i = 0; i < CMAX; i++) req(0, 5);
    chk("R5", "gate5 cleared after unwinding", 64'(bank1[15]), 64'(0));
    // pseudo-random mix
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req(lfsr[0] | lfsr[5], int'(lfsr[11:8]) % 10);
    end
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule